// File: doc/BRIEF.md
# Codec Host Serial Port (Device Side)

This block is the device end of a bidirectional synchronous serial link between a voice codec and a host processor. It makes the serial bit clock itself, dividing the master clock by five. It sends 16-bit words to the host, each one announced by an output frame pulse. It receives 16-bit words that the host frames with its own frame pulse. Each received word goes to one of two destinations, chosen by a host-driven steering flag: the sample data register or the control register. Three bits of the control register drive a gain-select output for the analog stage.

On the codec side the block has plain parallel registers. A word to transmit is loaded together with a one-cycle request strobe. Each received word appears with a one-cycle valid strobe that names its destination. Chip select gates the whole port. A powerdown input stops framing while the bit clock keeps running and the data line holds its last bit.

Top module: `codec_sport`

## Requirements
- R1: While `rst` is high and `cs` is high, `sclk`, `sdo` and `sdofs` are low from the first clock edge on, `port_oe` is high, and after reset `gain_sel` is 0.
- R2: With `cs` high and out of reset, `sclk` repeats with a period of 5 master clocks. It is high for 2 of them and low for 3.
- R3: A pending transmit word is sent as follows. `sdofs` is driven high at one rising `sclk` edge and stays high for exactly one `sclk` period. The 16 bits follow on `sdo`, most significant bit first, one per rising edge, starting at the next rising edge.
- R4: If no transmit request is pending, no frame starts: `sdofs` stays low and `sdo` keeps the last bit it drove (0 after reset).
- R5: The block samples `sdifs` on falling `sclk` edges. Once it is seen high, the next 16 falling edges sample `sdi`, most significant bit first. The assembled word is then presented with a one-master-clock valid pulse.
- R6: `dc_flag` is sampled together with `sdifs`. A value of 1 sends the word to `rx_data` with `rx_data_vld`. A value of 0 sends it to `ctrl_word` with `ctrl_vld`. A data word leaves `ctrl_word` unchanged.
- R7: `gain_sel` equals bits 9:7 of the last control word received, with bit 9 as its MSB. It changes only after a control write.
- R8: While `cs` is low, `port_oe` is low and `sclk`, `sdo` and `sdofs` are low. Host frames produce no word. A transmit request made while `cs` is low is dropped and starts no frame after `cs` returns.
- R9: While `pwrdn` is high (with `cs` high), `sclk` keeps toggling, `sdofs` stays low, `sdo` holds its last value and host frames are ignored. A request made in powerdown is sent after `pwrdn` falls.
- R10: If a new request is pending when the 16th bit of a frame ends, the next frame's `sdofs` pulse is driven at the very next rising `sclk` edge, with no idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, high enables the port |
| pwrdn | input | 1 | Powerdown request |
| tx_word | input | 16 | Word to transmit |
| tx_req | input | 1 | One-cycle strobe loading `tx_word` |
| sdi | input | 1 | Serial data from host |
| sdifs | input | 1 | Host frame pulse for `sdi` |
| dc_flag | input | 1 | Host steering flag: 1 data, 0 control |
| sclk | output | 1 | Serial bit clock (master clock / 5) |
| sdo | output | 1 | Serial data to host |
| sdofs | output | 1 | Frame pulse for `sdo` |
| port_oe | output | 1 | Drive enable for `sclk`, `sdo`, `sdofs` |
| rx_data | output | 16 | Last received data word |
| rx_data_vld | output | 1 | One-cycle pulse: new `rx_data` |
| ctrl_word | output | 16 | Control register |
| ctrl_vld | output | 1 | One-cycle pulse: new `ctrl_word` |
| gain_sel | output | 3 | Output gain select (control bits 9:7) |

## Verification
The assertions assume the host changes `sdi`, `sdifs` and `dc_flag` only after a rising `sclk` edge and holds them until the next one. They also assume `dc_flag` is valid whenever `sdifs` is high and that `tx_req` is a single-cycle pulse. The stimulus respects this. It watches `sclk` shortly after each master-clock edge, and after it sees a rise it drives the host lines at the following master-clock falling edge, which is well before the block's sampling edge two master clocks later. Requests are always one master clock wide and are issued on falling master-clock edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned DIV_N    = 5;
    localparam int unsigned HIGH_CYC = 2;
    localparam int unsigned GAIN_LSB = 7;
    localparam int unsigned GAIN_W   = 3;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_LEAD  = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    function automatic int unsigned cnt_w(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv import ssp_pkg::*; #(
    parameter int unsigned DIV  = DIV_N,
    parameter int unsigned HIGH = HIGH_CYC
) (
    input  logic      clk,
    input  logic      clr,
    output logic      sclk_q,
    output sclk_evt_t evt
);
    localparam int unsigned   CW     = cnt_w(DIV);
    localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
    localparam logic [CW-1:0] HIGH_C = CW'(HIGH);
    localparam logic [CW-1:0] FALL_C = CW'(HIGH - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        evt.rise = (cnt_q == LAST_C);
        evt.fall = (cnt_q == FALL_C);
        cnt_d    = evt.rise ? '0 : cnt_q + 1'b1;
    end

    // Counter starts at its last value so the first edge out of clear is a rise.
    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q  <= LAST_C;
            sclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            sclk_q <= (cnt_d < HIGH_C);
        end
    end

    assert_high_two_R2: assert property (@(posedge clk) disable iff (clr)
        $rose(sclk_q) && !$past(clr) |=> sclk_q);
    assert_high_ends_R2: assert property (@(posedge clk) disable iff (clr)
        sclk_q && $past(sclk_q) |=> !sclk_q);
    assert_low_three_R2: assert property (@(posedge clk) disable iff (clr)
        $fell(sclk_q) && !$past(clr) |=> !sclk_q ##1 !sclk_q);

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx import ssp_pkg::*; #(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         pwrdn,
    input  logic         rise_evt,
    input  logic [W-1:0] tx_word,
    input  logic         tx_req,
    output logic         sdo_q,
    output logic         sdofs_q
);
    localparam int unsigned    BCW = $clog2(W + 1);
    localparam logic [BCW-1:0] W_C = BCW'(W);

    tx_state_e      st_q;
    logic [W-1:0]   hold_q;
    logic [W-1:0]   shreg_q;
    logic           pend_q;
    logic [BCW-1:0] bits_q;
    logic           at_boundary;
    logic           start_ok;

    always_comb begin
        at_boundary = (st_q == TX_IDLE) || ((st_q == TX_SHIFT) && (bits_q == W_C));
        start_ok    = rise_evt && pend_q && !pwrdn && at_boundary;
    end

    // Request holding register: a later request replaces an unsent one.
    always_ff @(posedge clk) begin
        if (clr) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (tx_req) begin
            hold_q <= tx_word;
            pend_q <= 1'b1;
        end else if (start_ok) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q    <= TX_IDLE;
            shreg_q <= '0;
            bits_q  <= '0;
            sdo_q   <= 1'b0;
            sdofs_q <= 1'b0;
        end else if (pwrdn) begin
            st_q    <= TX_IDLE;
            sdofs_q <= 1'b0;
        end else if (rise_evt) begin
            if (start_ok) begin
                shreg_q <= hold_q;
                sdofs_q <= 1'b1;
                bits_q  <= '0;
                st_q    <= TX_LEAD;
            end else begin
                sdofs_q <= 1'b0;
                unique case (st_q)
                    TX_LEAD, TX_SHIFT: begin
                        if (bits_q == W_C) begin
                            st_q <= TX_IDLE;
                        end else begin
                            sdo_q   <= shreg_q[W-1];
                            shreg_q <= {shreg_q[W-2:0], 1'b0};
                            bits_q  <= bits_q + 1'b1;
                            st_q    <= TX_SHIFT;
                        end
                    end
                    default: st_q <= TX_IDLE;
                endcase
            end
        end
    end

    assert_sdo_on_rise_R3: assert property (@(posedge clk) disable iff (clr)
        !$stable(sdo_q) |-> $past(rise_evt) || $past(clr));
    assert_frame_needs_req_R4: assert property (@(posedge clk) disable iff (clr)
        $rose(sdofs_q) |-> $past(pend_q));
    assert_pd_no_frame_R9: assert property (@(posedge clk) disable iff (clr)
        pwrdn |=> !sdofs_q);
    assert_pd_holds_sdo_R9: assert property (@(posedge clk) disable iff (clr)
        pwrdn && !$past(clr) |=> $stable(sdo_q));

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx import ssp_pkg::*; #(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         pwrdn,
    input  logic         fall_evt,
    input  logic         sdi,
    input  logic         sdifs,
    input  logic         dc_flag,
    output logic [W-1:0] word_q,
    output logic         is_data_q,
    output logic         we_q
);
    localparam int unsigned   CW     = cnt_w(W);
    localparam logic [CW-1:0] LAST_C = CW'(W - 1);

    rx_state_e     st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q      <= RX_IDLE;
            cnt_q     <= '0;
            word_q    <= '0;
            is_data_q <= 1'b0;
            we_q      <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (pwrdn) begin
                st_q <= RX_IDLE;
            end else if (fall_evt) begin
                unique case (st_q)
                    RX_IDLE: begin
                        if (sdifs) begin
                            is_data_q <= dc_flag;
                            cnt_q     <= '0;
                            st_q      <= RX_SHIFT;
                        end
                    end
                    RX_SHIFT: begin
                        word_q <= {word_q[W-2:0], sdi};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == LAST_C) begin
                            we_q <= 1'b1;
                            st_q <= RX_IDLE;
                        end
                    end
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end

    assert_word_on_fall_R5: assert property (@(posedge clk) disable iff (clr)
        we_q |-> $past(fall_evt) && !$past(pwrdn));
    assert_pd_no_word_R9: assert property (@(posedge clk) disable iff (clr)
        pwrdn |=> !we_q);

endmodule

// File: rtl/ssp_regs.sv
module ssp_regs import ssp_pkg::*; #(
    parameter int unsigned W    = WORD_W,
    parameter int unsigned GLSB = GAIN_LSB,
    parameter int unsigned GW   = GAIN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          is_data,
    input  logic [W-1:0]  word,
    output logic [W-1:0]  data_q,
    output logic          data_vld_q,
    output logic [W-1:0]  ctrl_q,
    output logic          ctrl_vld_q,
    output logic [GW-1:0] gain
);
    logic data_we;
    logic ctrl_we;

    always_comb begin
        data_we = we && is_data;
        ctrl_we = we && !is_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q     <= '0;
            ctrl_q     <= '0;
            data_vld_q <= 1'b0;
            ctrl_vld_q <= 1'b0;
        end else begin
            data_vld_q <= data_we;
            ctrl_vld_q <= ctrl_we;
            if (data_we) data_q <= word;
            if (ctrl_we) ctrl_q <= word;
        end
    end

    assign gain = ctrl_q[GLSB +: GW];

    assert_ctrl_only_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> $past(we && !is_data) || $past(rst));
    assert_gain_only_on_write_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(gain) |-> $past(ctrl_we) || $past(rst));

endmodule

// File: rtl/codec_sport.sv
module codec_sport import ssp_pkg::*; #(
    parameter int unsigned W    = WORD_W,
    parameter int unsigned DIV  = DIV_N,
    parameter int unsigned HIGH = HIGH_CYC,
    parameter int unsigned GLSB = GAIN_LSB,
    parameter int unsigned GW   = GAIN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          pwrdn,
    input  logic [W-1:0]  tx_word,
    input  logic          tx_req,
    input  logic          sdi,
    input  logic          sdifs,
    input  logic          dc_flag,
    output logic          sclk,
    output logic          sdo,
    output logic          sdofs,
    output logic          port_oe,
    output logic [W-1:0]  rx_data,
    output logic          rx_data_vld,
    output logic [W-1:0]  ctrl_word,
    output logic          ctrl_vld,
    output logic [GW-1:0] gain_sel
);
    logic         port_clr;
    logic         sclk_q;
    sclk_evt_t    evt;
    logic         sdo_q;
    logic         sdofs_q;
    logic [W-1:0] rx_word;
    logic         rx_is_data;
    logic         rx_we;

    assign port_clr = rst || !cs;

    ssp_clkdiv #(.DIV(DIV), .HIGH(HIGH)) u_clkdiv (
        .clk    (clk),
        .clr    (port_clr),
        .sclk_q (sclk_q),
        .evt    (evt)
    );

    ssp_tx #(.W(W)) u_tx (
        .clk      (clk),
        .clr      (port_clr),
        .pwrdn    (pwrdn),
        .rise_evt (evt.rise),
        .tx_word  (tx_word),
        .tx_req   (tx_req),
        .sdo_q    (sdo_q),
        .sdofs_q  (sdofs_q)
    );

    ssp_rx #(.W(W)) u_rx (
        .clk       (clk),
        .clr       (port_clr),
        .pwrdn     (pwrdn),
        .fall_evt  (evt.fall),
        .sdi       (sdi),
        .sdifs     (sdifs),
        .dc_flag   (dc_flag),
        .word_q    (rx_word),
        .is_data_q (rx_is_data),
        .we_q      (rx_we)
    );

    ssp_regs #(.W(W), .GLSB(GLSB), .GW(GW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (rx_we),
        .is_data    (rx_is_data),
        .word       (rx_word),
        .data_q     (rx_data),
        .data_vld_q (rx_data_vld),
        .ctrl_q     (ctrl_word),
        .ctrl_vld_q (ctrl_vld),
        .gain       (gain_sel)
    );

    // Pins read low whenever the port is deselected.
    assign port_oe = cs;
    assign sclk    = cs && sclk_q;
    assign sdo     = cs && sdo_q;
    assign sdofs   = cs && sdofs_q;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!cs)
        rst |=> !sclk && !sdo && !sdofs);
    assert_deselect_no_word_R8: assert property (@(posedge clk) disable iff (rst)
        !cs && $past(!cs) |=> !rx_data_vld && !ctrl_vld);
    assert_single_dest_R6: assert property (@(posedge clk) disable iff (rst)
        rx_we |=> $onehot0({rx_data_vld, ctrl_vld}) && (rx_data_vld || ctrl_vld));

endmodule

// File: tb/codec_sport_test.sv
`timescale 1ns/1ps
module codec_sport_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b1;
    logic        pwrdn = 1'b0;
    logic [15:0] tx_word = '0;
    logic        tx_req = 1'b0;
    logic        sdi = 1'b0;
    logic        sdifs = 1'b0;
    logic        dc_flag = 1'b0;
    logic        sclk, sdo, sdofs, port_oe, rx_data_vld, ctrl_vld;
    logic [15:0] rx_data, ctrl_word;
    logic [2:0]  gain_sel;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    codec_sport uut (
        .clk(clk), .rst(rst), .cs(cs), .pwrdn(pwrdn),
        .tx_word(tx_word), .tx_req(tx_req),
        .sdi(sdi), .sdifs(sdifs), .dc_flag(dc_flag),
        .sclk(sclk), .sdo(sdo), .sdofs(sdofs), .port_oe(port_oe),
        .rx_data(rx_data), .rx_data_vld(rx_data_vld),
        .ctrl_word(ctrl_word), .ctrl_vld(ctrl_vld), .gain_sel(gain_sel)
    );

    // Scoreboard queues
    logic [15:0] txq[$];
    logic [16:0] rxq[$];
    bit          tx_active = 0;
    bit          b2b_expect = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: sampled 2 ns after each master clock rise
    initial begin
        logic        prev = 1'b1;
        logic [15:0] got = '0;
        logic [15:0] exp_w = '0;
        int          nb = 0;
        bit          just_done = 0;
        forever begin
            @(posedge clk); #2;
            if (rx_data_vld) begin
                if (rxq.size() == 0) check(0, "R5 R6 unexpected data word", rx_data, 0);
                else begin
                    logic [16:0] e; e = rxq.pop_front();
                    check(e[16] == 1'b1 && rx_data == e[15:0], "R5 R6 data word", {1'b1, rx_data}, e);
                end
            end
            if (ctrl_vld) begin
                if (rxq.size() == 0) check(0, "R5 R6 unexpected control word", ctrl_word, 0);
                else begin
                    logic [16:0] e; e = rxq.pop_front();
                    check(e[16] == 1'b0 && ctrl_word == e[15:0], "R5 R6 control word", {1'b0, ctrl_word}, e);
                end
            end
            if (sclk && !prev) begin
                if (just_done && b2b_expect) begin
                    check(sdofs == 1'b1, "R10 back-to-back frame pulse", sdofs, 1);
                    b2b_expect = 0;
                end
                just_done = 0;
                if (tx_active) begin
                    check(sdofs == 1'b0, "R3 frame pulse one period", sdofs, 0);
                    got = {got[14:0], sdo};
                    nb++;
                    if (nb == 16) begin
                        check(got == exp_w, "R3 transmitted word", got, exp_w);
                        tx_active = 0;
                        just_done = 1;
                    end
                end else if (sdofs) begin
                    if (txq.size() == 0) check(0, "R4 R8 frame without request", 1, 0);
                    else begin
                        exp_w = txq.pop_front();
                        tx_active = 1;
                        nb = 0;
                        got = '0;
                    end
                end
            end
            prev = sclk;
        end
    end

    task automatic wait_rise();
        logic p = 1'b1;
        bit seen = 0;
        while (!seen) begin
            @(posedge clk); #2;
            seen = sclk && !p;
            p = sclk;
        end
    endtask

    task automatic send_tx(input logic [15:0] w, input bit expect_it);
        @(negedge clk);
        tx_word = w; tx_req = 1'b1;
        if (expect_it) txq.push_back(w);
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic host_frame(input logic is_data, input logic [15:0] w, input bit expect_it);
        wait_rise(); @(negedge clk);
        sdifs = 1'b1; dc_flag = is_data;
        if (expect_it) rxq.push_back({is_data, w});
        for (int i = 15; i >= 0; i--) begin
            wait_rise(); @(negedge clk);
            sdifs = 1'b0; dc_flag = 1'b0; sdi = w[i];
        end
        wait_rise(); @(negedge clk);
        sdi = 1'b0;
    endtask

    task automatic wait_tx_idle();
        int n = 0;
        while ((txq.size() != 0 || tx_active) && n < 2000) begin
            @(posedge clk); #2; n++;
        end
        check(n < 2000, "R3 transmit drained", n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic last_bit;
        // R1: reset with chip select high
        repeat (3) @(posedge clk); #2;
        check(sclk == 0 && sdo == 0 && sdofs == 0, "R1 pins low in reset", {sclk, sdo, sdofs}, 0);
        check(port_oe == 1'b1, "R1 port enabled in reset", port_oe, 1);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2;
        check(gain_sel == 3'd0, "R1 gain after reset", gain_sel, 0);

        // R2: clock shape
        begin
            int per = 0, hi = 0;
            wait_rise();
            do begin
                if (sclk) hi++;
                per++;
                @(posedge clk); #2;
            end while (!(sclk && per > 0 && hi == per - 0 && 0) && !(sclk && !(per == hi)));
            check(per == 5, "R2 sclk period", per, 5);
            check(hi == 2, "R2 sclk high time", hi, 2);
        end

        // R4: idle, no request
        repeat (40) @(posedge clk); #2;
        check(sdofs == 0 && sdo == 0, "R4 idle pins", {sdofs, sdo}, 0);

        // R3: single word, last bit 1
        send_tx(16'hA5C3, 1);
        wait_tx_idle();
        repeat (30) @(posedge clk); #2;
        check(sdo == 1'b1 && sdofs == 1'b0, "R4 sdo holds last bit", {sdofs, sdo}, 1);

        // R10: back-to-back
        send_tx(16'h3C5A, 1);
        while (!tx_active) begin @(posedge clk); #2; end
        b2b_expect = 1;
        send_tx(16'h8001, 1);
        wait_tx_idle();
        check(b2b_expect == 0, "R10 back-to-back observed", b2b_expect, 0);

        // R5 R6 R7: receive control then data
        host_frame(1'b0, 16'h12A9, 1);
        @(posedge clk); #2;
        check(gain_sel == 3'd5, "R7 gain from control bits 9:7", gain_sel, 5);
        host_frame(1'b1, 16'hBEEF, 1);
        @(posedge clk); #2;
        check(ctrl_word == 16'h12A9 && gain_sel == 3'd5, "R6 data word leaves control", ctrl_word, 16'h12A9);
        host_frame(1'b0, 16'h0100, 1);
        @(posedge clk); #2;
        check(gain_sel == 3'd2, "R7 gain second control", gain_sel, 2);

        // Both directions together
        fork
            host_frame(1'b1, 16'h0F0F, 1);
            send_tx(16'h7FFE, 1);
        join
        wait_tx_idle();
        last_bit = 1'b0;

        // R9: powerdown
        @(negedge clk); pwrdn = 1'b1;
        begin
            int rises = 0;
            for (int k = 0; k < 30; k++) begin
                logic p; p = sclk;
                @(posedge clk); #2;
                if (sclk && !p) rises++;
            end
            check(rises >= 5, "R9 sclk runs in powerdown", rises, 6);
        end
        check(sdo == last_bit && sdofs == 1'b0, "R9 sdo holds, no frame pulse", {sdofs, sdo}, last_bit);
        send_tx(16'hC001, 1);
        host_frame(1'b1, 16'hDEAD, 0);
        repeat (20) @(posedge clk); #2;
        check(sdofs == 1'b0 && sdo == last_bit && !tx_active, "R9 request held in powerdown", {sdofs, sdo}, last_bit);
        check(rx_data == 16'h0F0F, "R9 host frame ignored", rx_data, 16'h0F0F);
        @(negedge clk); pwrdn = 1'b0;
        wait_tx_idle();

        // R8: chip select low
        @(negedge clk); cs = 1'b0;
        send_tx(16'h5555, 0);
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            sdifs = (k % 20) == 1;
            dc_flag = 1'b0;
            sdi = k[0];
        end
        @(posedge clk); #2;
        check(port_oe == 0 && sclk == 0 && sdo == 0 && sdofs == 0, "R8 deselected pins", {port_oe, sclk, sdo, sdofs}, 0);
        check(gain_sel == 3'd2 && rx_data == 16'h0F0F, "R8 no word while deselected", gain_sel, 2);
        @(negedge clk); sdifs = 1'b0; sdi = 1'b0; cs = 1'b1;
        repeat (80) @(posedge clk); #2;
        check(!tx_active && sdofs == 0, "R8 dropped request sends nothing", sdofs, 0);
        host_frame(1'b1, 16'h1234, 1);
        @(posedge clk); #2;
        check(rxq.size() == 0, "R5 receive after reselect", rxq.size(), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule